// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline Front End

This block finds the one data dependency that result forwarding cannot cover. When the instruction now in execute is a memory load and the instruction behind it in decode reads the register that load will write, the loaded value does not exist in time. The block holds the program counter and the fetch/decode register for one cycle. It also sends an all-zero control bundle into the decode/execute register, so that a harmless empty slot moves down the pipe in place of the dependent instruction. On the next cycle the dependent instruction issues normally, and the loaded value reaches it through the late forwarding path.

The detector is delivered together with the three pieces of state it steers: the fetch counter, the fetch/decode register and the decode/execute register with its zeroing multiplexer. This lets the effect of an interlock be seen at the ports. Instruction fetch is external. The block presents `fetch_pc`, and the environment returns the source registers, the target register and the control bundle of the instruction at that address in the same cycle. Bit 0 of the control bundle marks a memory read.

Top module: `ldu_interlock_pipe`

## Requirements
- R1: While `rst_n` is low, `fetch_pc`, `dec_pc`, `idex_pc`, `idex_rt` and `idex_ctrl` are all zero and `stall` is 0.
- R2: `stall` is 1 exactly when bit 0 of the execute-stage control bundle is 1, the execute-stage target register is nonzero, and that register equals either source register of the decode-stage instruction.
- R3: After an edge with `stall` high, `fetch_pc` is unchanged. After an edge with `stall` low, it has advanced by `PC_INC` modulo 2^`PC_W`.
- R4: After an edge with `stall` high, the decode stage still holds the same instruction (same `dec_pc`). After an edge with `stall` low, it holds the instruction fetched at the previous `fetch_pc`.
- R5: After an edge with `stall` high, `idex_ctrl` is all zeros. After an edge with `stall` low, it equals the decode instruction's control bundle.
- R6: In the same cycle as `stall`, `pc_we` and `ifid_we` equal its inverse and `bubble_sel` equals it.
- R7: A load whose target register is register 0 never raises `stall`.
- R8: Each load-use pair costs exactly one stall cycle: the cycle after a stall never stalls again for the same load.
- R9: Every fetched instruction enters the execute stage exactly once, in program order, so `idex_pc` follows the decode-stage `dec_pc` of the previous cycle. The instruction after a stalled one is held along with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | output | PC_W | Address of the instruction being fetched |
| imem_rs | input | REG_AW | First source register of the instruction at `fetch_pc` |
| imem_rt | input | REG_AW | Second source / load target register of the instruction at `fetch_pc` |
| imem_ctrl | input | CTRL_W | Control bundle of the instruction at `fetch_pc`; bit 0 = memory read |
| dec_pc | output | PC_W | Address of the instruction in decode |
| idex_pc | output | PC_W | Address of the instruction in execute |
| idex_rt | output | REG_AW | Target register of the instruction in execute |
| idex_ctrl | output | CTRL_W | Control bundle in execute (zero for an inserted slot) |
| stall | output | 1 | Load-use interlock active this cycle |
| pc_we | output | 1 | Fetch counter update enable |
| ifid_we | output | 1 | Fetch/decode register update enable |
| bubble_sel | output | 1 | Selects an all-zero control bundle into execute |

## Verification
The bench builds the block with `PC_W`=6, `REG_AW`=3, `CTRL_W`=4 and `PC_INC`=1. With only eight registers, chance register matches are frequent. The 64-entry address space wraps several times in one run, which exercises the modulo advance of the fetch counter. A directed head of the program places a load followed by a user through the first source, a user through the second source, a load to register 0, a non-load producer, and a load followed by a dependent load followed by its own user. That last case gives two stalls one slot apart.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

    // Position of the memory-read flag inside a control bundle.
    localparam int unsigned LDU_RD_BIT = 0;

    // Action taken by the front end in a given cycle.
    typedef enum logic {
        FLOW_RUN  = 1'b0,
        FLOW_HOLD = 1'b1
    } flow_e;

endpackage

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect
    import ldu_pkg::*;
#(
    parameter int unsigned REG_AW = 5,
    parameter int unsigned CTRL_W = 8
) (
    input  logic [REG_AW-1:0] dec_rs,
    input  logic [REG_AW-1:0] dec_rt,
    input  logic [CTRL_W-1:0] ex_ctrl,
    input  logic [REG_AW-1:0] ex_rt,
    output logic              stall,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              bubble_sel
);

    localparam int unsigned NSRC = 2;

    logic [REG_AW-1:0] src [NSRC];
    logic [NSRC-1:0]   hit;
    logic              ex_is_load;
    logic              ex_rt_live;
    flow_e             flow;

    assign src[0] = dec_rs;
    assign src[1] = dec_rt;

    // One comparator per decode-stage source operand.
    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign hit[g] = (src[g] == ex_rt);
    end

    always_comb begin
        ex_is_load = ex_ctrl[LDU_RD_BIT];
        ex_rt_live = (ex_rt != '0);
        flow       = (ex_is_load && ex_rt_live && (|hit)) ? FLOW_HOLD : FLOW_RUN;
        stall      = (flow == FLOW_HOLD);
        pc_we      = (flow == FLOW_RUN);
        ifid_we    = (flow == FLOW_RUN);
        bubble_sel = (flow == FLOW_HOLD);
    end

endmodule

// File: rtl/ldu_pc_reg.sv
module ldu_pc_reg #(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned PC_INC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_we,
    output logic [PC_W-1:0] pc_q
);

    localparam logic [PC_W-1:0] STEP = PC_W'(PC_INC);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pc_we) begin
            st_d.pc = st_q.pc + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_q = st_q.pc;

endmodule

// File: rtl/ldu_ifid_reg.sv
module ldu_ifid_reg #(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned REG_AW = 5,
    parameter int unsigned CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [REG_AW-1:0] in_rs,
    input  logic [REG_AW-1:0] in_rt,
    input  logic [CTRL_W-1:0] in_ctrl,
    output logic [PC_W-1:0]   out_pc,
    output logic [REG_AW-1:0] out_rs,
    output logic [REG_AW-1:0] out_rt,
    output logic [CTRL_W-1:0] out_ctrl
);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [CTRL_W-1:0] ctrl;
    } dec_slot_t;

    dec_slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.pc   = in_pc;
            st_d.rs   = in_rs;
            st_d.rt   = in_rt;
            st_d.ctrl = in_ctrl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_pc   = st_q.pc;
    assign out_rs   = st_q.rs;
    assign out_rt   = st_q.rt;
    assign out_ctrl = st_q.ctrl;

endmodule

// File: rtl/ldu_idex_reg.sv
module ldu_idex_reg #(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned REG_AW = 5,
    parameter int unsigned CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bubble_sel,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [REG_AW-1:0] in_rt,
    input  logic [CTRL_W-1:0] in_ctrl,
    output logic [PC_W-1:0]   out_pc,
    output logic [REG_AW-1:0] out_rt,
    output logic [CTRL_W-1:0] out_ctrl
);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [REG_AW-1:0] rt;
        logic [CTRL_W-1:0] ctrl;
    } ex_slot_t;

    ex_slot_t          st_d, st_q;
    logic [CTRL_W-1:0] ctrl_mux;

    // Zeroing multiplexer, one gate per control bit.
    for (genvar b = 0; b < CTRL_W; b++) begin : g_zero
        assign ctrl_mux[b] = in_ctrl[b] & ~bubble_sel;
    end

    always_comb begin
        st_d      = st_q;
        st_d.pc   = in_pc;
        st_d.rt   = in_rt;
        st_d.ctrl = ctrl_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_pc   = st_q.pc;
    assign out_rt   = st_q.rt;
    assign out_ctrl = st_q.ctrl;

endmodule

// File: rtl/ldu_interlock_pipe.sv
module ldu_interlock_pipe #(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned REG_AW = 5,
    parameter int unsigned CTRL_W = 8,
    parameter int unsigned PC_INC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   fetch_pc,
    input  logic [REG_AW-1:0] imem_rs,
    input  logic [REG_AW-1:0] imem_rt,
    input  logic [CTRL_W-1:0] imem_ctrl,
    output logic [PC_W-1:0]   dec_pc,
    output logic [PC_W-1:0]   idex_pc,
    output logic [REG_AW-1:0] idex_rt,
    output logic [CTRL_W-1:0] idex_ctrl,
    output logic              stall,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              bubble_sel
);

    logic [REG_AW-1:0] dec_rs;
    logic [REG_AW-1:0] dec_rt;
    logic [CTRL_W-1:0] dec_ctrl;

    ldu_hazard_detect #(
        .REG_AW (REG_AW),
        .CTRL_W (CTRL_W)
    ) u_detect (
        .dec_rs     (dec_rs),
        .dec_rt     (dec_rt),
        .ex_ctrl    (idex_ctrl),
        .ex_rt      (idex_rt),
        .stall      (stall),
        .pc_we      (pc_we),
        .ifid_we    (ifid_we),
        .bubble_sel (bubble_sel)
    );

    ldu_pc_reg #(
        .PC_W   (PC_W),
        .PC_INC (PC_INC)
    ) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .pc_we (pc_we),
        .pc_q  (fetch_pc)
    );

    ldu_ifid_reg #(
        .PC_W   (PC_W),
        .REG_AW (REG_AW),
        .CTRL_W (CTRL_W)
    ) u_ifid (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ifid_we),
        .in_pc    (fetch_pc),
        .in_rs    (imem_rs),
        .in_rt    (imem_rt),
        .in_ctrl  (imem_ctrl),
        .out_pc   (dec_pc),
        .out_rs   (dec_rs),
        .out_rt   (dec_rt),
        .out_ctrl (dec_ctrl)
    );

    ldu_idex_reg #(
        .PC_W   (PC_W),
        .REG_AW (REG_AW),
        .CTRL_W (CTRL_W)
    ) u_idex (
        .clk        (clk),
        .rst_n      (rst_n),
        .bubble_sel (bubble_sel),
        .in_pc      (dec_pc),
        .in_rt      (dec_rt),
        .in_ctrl    (dec_ctrl),
        .out_pc     (idex_pc),
        .out_rt     (idex_rt),
        .out_ctrl   (idex_ctrl)
    );

endmodule

// File: rtl/ldu_interlock_chk.sv
module ldu_interlock_chk #(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned REG_AW = 5,
    parameter int unsigned CTRL_W = 8,
    parameter int unsigned PC_INC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   fetch_pc,
    input logic [PC_W-1:0]   dec_pc,
    input logic [PC_W-1:0]   idex_pc,
    input logic [REG_AW-1:0] idex_rt,
    input logic [CTRL_W-1:0] idex_ctrl,
    input logic              stall,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              bubble_sel
);

    localparam logic [PC_W-1:0] STEP = PC_W'(PC_INC);

    always_comb begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (fetch_pc == '0 && dec_pc == '0 && idex_pc == '0 &&
                                           idex_ctrl == '0 && !stall);
        end
    end

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (fetch_pc == $past(fetch_pc)));

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (fetch_pc == PC_W'($past(fetch_pc) + STEP)));

    assert_dec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (dec_pc == $past(dec_pc)));

    assert_bubble_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (idex_ctrl == '0));

    assert_ctrl_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == !stall) && (ifid_we == !stall) && (bubble_sel == stall));

    assert_r0_never_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rt == '0) |-> !stall);

    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    assert_issue_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (idex_pc == $past(dec_pc)));

endmodule

bind ldu_interlock_pipe ldu_interlock_chk #(
    .PC_W   (PC_W),
    .REG_AW (REG_AW),
    .CTRL_W (CTRL_W),
    .PC_INC (PC_INC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_pc   (fetch_pc),
    .dec_pc     (dec_pc),
    .idex_pc    (idex_pc),
    .idex_rt    (idex_rt),
    .idex_ctrl  (idex_ctrl),
    .stall      (stall),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .bubble_sel (bubble_sel)
);

// File: tb/sim_ldu_interlock_pipe.sv
module sim_ldu_interlock_pipe;

    localparam int PC_W   = 6;
    localparam int REG_AW = 3;
    localparam int CTRL_W = 4;
    localparam int PC_INC = 1;
    localparam int NPC    = 1 << PC_W;
    localparam int RUN_CYC = 300;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   fetch_pc;
    logic [REG_AW-1:0] imem_rs;
    logic [REG_AW-1:0] imem_rt;
    logic [CTRL_W-1:0] imem_ctrl;
    logic [PC_W-1:0]   dec_pc;
    logic [PC_W-1:0]   idex_pc;
    logic [REG_AW-1:0] idex_rt;
    logic [CTRL_W-1:0] idex_ctrl;
    logic              stall;
    logic              pc_we;
    logic              ifid_we;
    logic              bubble_sel;

    int n_chk = 0;
    int n_bad = 0;
    int n_stalls = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ldu_interlock_pipe #(
        .PC_W (PC_W), .REG_AW (REG_AW), .CTRL_W (CTRL_W), .PC_INC (PC_INC)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .fetch_pc (fetch_pc),
        .imem_rs (imem_rs), .imem_rt (imem_rt), .imem_ctrl (imem_ctrl),
        .dec_pc (dec_pc), .idex_pc (idex_pc), .idex_rt (idex_rt),
        .idex_ctrl (idex_ctrl), .stall (stall), .pc_we (pc_we),
        .ifid_we (ifid_we), .bubble_sel (bubble_sel)
    );

    // Program: control bit 0 marks a load. Directed head, then a hashed body.
    function automatic int p_rs(int i);
        case (i)
            0: return 1;  1: return 3;  2: return 2;  3: return 1;
            4: return 0;  5: return 1;  6: return 7;  7: return 1;
            8: return 5;  9: return 2;  10: return 6; 11: return 6;
            default: return (i * 3 + 1) % 8;
        endcase
    endfunction

    function automatic int p_rt(int i);
        case (i)
            0: return 1;  1: return 2;  2: return 5;  3: return 0;
            4: return 0;  5: return 4;  6: return 4;  7: return 5;
            8: return 5;  9: return 6;  10: return 6; 11: return 1;
            default: return (i * 5 + 2) % 8;
        endcase
    endfunction

    function automatic int p_ctrl(int i);
        case (i)
            1, 3, 5, 9, 10: return 3;
            0, 2, 4, 6, 7, 8, 11: return 2;
            default: return (i % 3 == 0) ? 11 : 6;
        endcase
    endfunction

    always_comb begin
        imem_rs   = REG_AW'(p_rs(int'(fetch_pc)));
        imem_rt   = REG_AW'(p_rt(int'(fetch_pc)));
        imem_ctrl = CTRL_W'(p_ctrl(int'(fetch_pc)));
    end

    // Behavioural reference state.
    int r_pc, r_dpc, r_drs, r_drt, r_dctl, r_xpc, r_xrt, r_xctl;
    bit r_prev_stall;

    function automatic bit ref_stall();
        return (r_xctl % 2 == 1) && (r_xrt != 0) && (r_xrt == r_drs || r_xrt == r_drt);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            r_pc = 0; r_dpc = 0; r_drs = 0; r_drt = 0; r_dctl = 0;
            r_xpc = 0; r_xrt = 0; r_xctl = 0; r_prev_stall = 0;
        end else begin
            bit s;
            s = ref_stall();
            r_prev_stall = s;
            if (s) begin
                r_xpc = r_dpc; r_xrt = r_drt; r_xctl = 0;
            end else begin
                r_xpc = r_dpc; r_xrt = r_drt; r_xctl = r_dctl;
                r_dpc = r_pc; r_drs = p_rs(r_pc); r_drt = p_rt(r_pc); r_dctl = p_ctrl(r_pc);
                r_pc = (r_pc + PC_INC) % NPC;
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state observed while reset is held
        check("R1 fetch_pc", int'(fetch_pc), 0);
        check("R1 dec_pc", int'(dec_pc), 0);
        check("R1 idex_ctrl", int'(idex_ctrl), 0);
        check("R1 stall", int'(stall), 0);
        rst_n = 1'b1;
        for (int c = 0; c < RUN_CYC; c++) begin
            @(negedge clk);
            begin
                bit es;
                es = ref_stall();
                if (es) n_stalls++;
                check("R2 stall", int'(stall), int'(es));
                check("R3 fetch_pc", int'(fetch_pc), r_pc);
                check("R4 dec_pc", int'(dec_pc), r_dpc);
                check("R5 idex_ctrl", int'(idex_ctrl), r_xctl);
                check("R6 pc_we", int'(pc_we), int'(!es));
                check("R6 ifid_we", int'(ifid_we), int'(!es));
                check("R6 bubble_sel", int'(bubble_sel), int'(es));
                if (r_xctl % 2 == 1 && r_xrt == 0) check("R7 r0 load", int'(stall), 0);
                if (r_prev_stall) check("R8 one cycle", int'(stall), 0);
                check("R9 idex_pc", int'(idex_pc), r_xpc);
                check("R9 idex_rt", int'(idex_rt), r_xrt);
            end
        end
        // R2: the directed head alone yields stalls, so some must have been seen
        check("R2 stalls seen", int'(n_stalls >= 4), 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule